// File: doc/BRIEF.md
# Fractional-N Main Divider Controller

This block divides a fast input clock by a programmable integer ratio N, stretching selected division cycles to N+1 so that the average ratio over a full accumulator period is N + NF/Q. A small modulo-Q accumulator advances by the fractional increment NF once per division cycle. Each time it wraps, the following cycle is lengthened by one input clock. The modulus Q can be 5 or 8.

A new ratio, increment, modulus and compensation code are staged by a one-clock load request. They go live together at the next division-cycle boundary and never in the middle of a cycle. After every boundary the block opens a compensation window of a fixed number of input clocks. With the window it gives an amplitude code, which is the product of the accumulator contents and the programmed DAC code. A charge-pump stage downstream uses the window and the code to cancel the phase ripple that the dithering produces.

Top module: `fracn_div_ctrl`

## Requirements
- R1: Each division cycle lasts N or N+1 input clocks. `div_pulse` is high for exactly one clock, on the last clock of each cycle.
- R2: At every cycle boundary the accumulator adds the effective increment. If the sum reaches Q, Q is subtracted once. `acc_val` always shows a value below Q.
- R3: `cfg_mod5` = 1 selects Q = 5 and `cfg_mod5` = 0 selects Q = 8. With Q = 5, an increment of 5, 6 or 7 is clamped to 4 when it is loaded.
- R4: When the accumulator wraps at a boundary, the cycle that follows lasts N+1 clocks, and otherwise N clocks. Starting from a cleared accumulator, exactly NF of any Q consecutive cycles are N+1 cycles.
- R5: Values staged by `cfg_load` take effect only at the first boundary after the load. The cycle in progress keeps its old length. At that boundary the accumulator restarts from zero before it adds the new increment.
- R6: `comp_en` rises on the clock after `div_pulse` and stays high for exactly 128 clocks. It is low whenever `div_pulse` is high.
- R7: While `comp_en` is high, `comp_amp` equals the accumulator value after the boundary multiplied by the 8-bit DAC code. It is 0 while `comp_en` is low.
- R8: A ratio below 512 is raised to 512 when it is loaded.
- R9: During reset, and until the first boundary, `acc_val` = 0, `comp_en` = 0 and `comp_amp` = 0. The active settings after reset are N = 512, NF = 0, Q = 8 and DAC code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | One-clock request to stage the cfg_* values |
| cfg_ratio | input | 16 | Integer divide ratio N (512 to 65535) |
| cfg_frac | input | 3 | Fractional increment NF |
| cfg_mod5 | input | 1 | Modulus select: 1 gives Q = 5, 0 gives Q = 8 |
| cfg_dac | input | 8 | Compensation DAC code |
| div_pulse | output | 1 | One-clock pulse at the end of each division cycle |
| acc_val | output | 3 | Current accumulator contents |
| comp_en | output | 1 | Compensation window enable |
| comp_amp | output | 11 | Compensation amplitude code, gated by comp_en |

## Verification
The assertions hold on every cycle. They check that the accumulator stays below its modulus and changes only at a boundary, that the active settings change only at a boundary and never hold a ratio under the floor, that the divider pulse lasts a single clock, and that the window opens right after a pulse and keeps a steady amplitude. The bench scenarios cover what needs arithmetic over many cycles. They check the exact sequence of N and N+1 lengths and the count of stretched cycles over a full period, for every increment under both moduli, including the clamped ones. They also check the length of the cycle in which a load arrives, the 128-clock window width and the ratio floor.

// File: rtl/fracn_pkg.sv
`timescale 1ns/1ps
package fracn_pkg;
  parameter int RATIO_W = 16;
  parameter int FRAC_W  = 3;
  parameter int DAC_W   = 8;

  localparam int ACC_W = FRAC_W;
  localparam int SUM_W = FRAC_W + 1;
  localparam int AMP_W = ACC_W + DAC_W;
  localparam int CNT_W = RATIO_W + 1;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic [FRAC_W-1:0]  frac;
    logic               mod5;
    logic [DAC_W-1:0]   dac;
  } fracn_cfg_t;

  // Accumulator modulus for a given select bit.
  function automatic logic [SUM_W-1:0] modulus(input logic mod5);
    return mod5 ? SUM_W'(5) : SUM_W'(8);
  endfunction
endpackage

// File: rtl/fracn_cfg_stage.sv
`timescale 1ns/1ps
module fracn_cfg_stage
  import fracn_pkg::*;
#(
  parameter int unsigned RATIO_MIN = 512,
  parameter int unsigned RST_RATIO = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  fracn_cfg_t cfg_i,
  input  logic       boundary_i,
  output fracn_cfg_t act_o,
  output fracn_cfg_t next_o,
  output logic       reload_o
);
  localparam fracn_cfg_t CFG_RST = '{ratio: RATIO_W'(RST_RATIO), frac: '0, mod5: 1'b0, dac: '0};
  localparam logic [FRAC_W-1:0] FRAC_LIM5 = FRAC_W'(5 - 1);

  fracn_cfg_t stage_q, stage_d, act_q, act_d, clamped;
  logic       pend_q, pend_d, reload;

  // Legalise values on capture so the live path never sees them out of range.
  always_comb begin
    clamped = cfg_i;
    if (cfg_i.ratio < RATIO_W'(RATIO_MIN)) clamped.ratio = RATIO_W'(RATIO_MIN);
    if (cfg_i.mod5 && (cfg_i.frac > FRAC_LIM5)) clamped.frac = FRAC_LIM5;
  end

  always_comb begin
    reload  = pend_q & boundary_i;
    stage_d = load_i ? clamped : stage_q;
    pend_d  = load_i | (pend_q & ~boundary_i);
    act_d   = reload ? stage_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= CFG_RST;
      pend_q  <= 1'b0;
      act_q   <= CFG_RST;
    end else begin
      stage_q <= stage_d;
      pend_q  <= pend_d;
      act_q   <= act_d;
    end
  end

  assign act_o    = act_q;
  assign next_o   = act_d;
  assign reload_o = reload;

  p_ratio_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    act_q.ratio >= RATIO_W'(RATIO_MIN));
  p_swap_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |=> $stable(act_q));
endmodule

// File: rtl/fracn_accum.sv
`timescale 1ns/1ps
module fracn_accum
  import fracn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              restart_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              mod5_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [ACC_W-1:0]  acc_next_o,
  output logic              carry_o
);
  logic [ACC_W-1:0] acc_q, acc_d, base;
  logic [SUM_W-1:0] sum, modq, wrapped;
  logic             carry;

  always_comb begin
    base    = restart_i ? '0 : acc_q;
    modq    = modulus(mod5_i);
    sum     = SUM_W'(base) + SUM_W'(frac_i);
    carry   = (sum >= modq);
    wrapped = carry ? (sum - modq) : sum;
    acc_d   = step_i ? ACC_W'(wrapped) : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o      = acc_q;
  assign acc_next_o = ACC_W'(wrapped);
  assign carry_o    = carry & step_i;

  p_acc_below_mod_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (SUM_W'(acc_q) < modulus($past(mod5_i))));
  p_acc_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(acc_q));
endmodule

// File: rtl/fracn_cycle_ctr.sv
`timescale 1ns/1ps
module fracn_cycle_ctr
  import fracn_pkg::*;
#(
  parameter int unsigned RST_RATIO = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] len_i,
  output logic             boundary_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  always_comb begin
    last  = (cnt_q == '0);
    cnt_d = last ? (len_i - CNT_W'(1)) : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(RST_RATIO - 1);
    else        cnt_q <= cnt_d;
  end

  assign boundary_o = last;

  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_o |=> !boundary_o);
endmodule

// File: rtl/fracn_comp_win.sv
`timescale 1ns/1ps
module fracn_comp_win
  import fracn_pkg::*;
#(
  parameter int unsigned WIN_LEN = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [DAC_W-1:0] dac_i,
  output logic             en_o,
  output logic [AMP_W-1:0] amp_o
);
  localparam int WIN_CW = $clog2(WIN_LEN + 1);

  logic [WIN_CW-1:0] win_q, win_d;
  logic [AMP_W-1:0]  amp_q, amp_d;
  logic              open;

  always_comb begin
    open  = (win_q != '0);
    if (pulse_i)   win_d = WIN_CW'(WIN_LEN);
    else if (open) win_d = win_q - WIN_CW'(1);
    else           win_d = win_q;
    amp_d = pulse_i ? (AMP_W'(acc_i) * AMP_W'(dac_i)) : amp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      amp_q <= '0;
    end else begin
      win_q <= win_d;
      amp_q <= amp_d;
    end
  end

  assign en_o  = open;
  assign amp_o = open ? amp_q : '0;

  p_win_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i |=> en_o);
  p_win_shut_at_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i |-> !en_o);
  p_amp_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && $past(en_o)) |-> $stable(amp_o));
endmodule

// File: rtl/fracn_div_ctrl.sv
`timescale 1ns/1ps
module fracn_div_ctrl
  import fracn_pkg::*;
#(
  parameter int unsigned RATIO_MIN = 512,
  parameter int unsigned RST_RATIO = 512,
  parameter int unsigned WIN_LEN   = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic [FRAC_W-1:0]  cfg_frac,
  input  logic               cfg_mod5,
  input  logic [DAC_W-1:0]   cfg_dac,
  output logic               div_pulse,
  output logic [ACC_W-1:0]   acc_val,
  output logic               comp_en,
  output logic [AMP_W-1:0]   comp_amp
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  fracn_cfg_t       cfg_in, cfg_act, cfg_next;
  logic             boundary, reload, carry;
  logic [ACC_W-1:0] acc_next;
  logic [CNT_W-1:0] cyc_len;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign cfg_in = '{ratio: cfg_ratio, frac: cfg_frac, mod5: cfg_mod5, dac: cfg_dac};

  fracn_cfg_stage #(.RATIO_MIN(RATIO_MIN), .RST_RATIO(RST_RATIO)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .load_i(cfg_load), .cfg_i(cfg_in),
    .boundary_i(boundary), .act_o(cfg_act), .next_o(cfg_next), .reload_o(reload)
  );

  fracn_accum u_acc (
    .clk(clk), .rst_n(rst_int_n), .step_i(boundary), .restart_i(reload),
    .frac_i(cfg_next.frac), .mod5_i(cfg_next.mod5),
    .acc_o(acc_val), .acc_next_o(acc_next), .carry_o(carry)
  );

  assign cyc_len = CNT_W'(cfg_next.ratio) + CNT_W'(carry);

  fracn_cycle_ctr #(.RST_RATIO(RST_RATIO)) u_ctr (
    .clk(clk), .rst_n(rst_int_n), .len_i(cyc_len), .boundary_o(boundary)
  );

  fracn_comp_win #(.WIN_LEN(WIN_LEN)) u_win (
    .clk(clk), .rst_n(rst_int_n), .pulse_i(boundary), .acc_i(acc_next),
    .dac_i(cfg_next.dac), .en_o(comp_en), .amp_o(comp_amp)
  );

  assign div_pulse = boundary;

  p_ratio_live_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    boundary |=> (cfg_act.ratio >= RATIO_W'(RATIO_MIN)) && !div_pulse);
endmodule

// File: tb/fracn_div_ctrl_bench.sv
`timescale 1ns/1ps
module fracn_div_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load;
  logic [15:0] cfg_ratio;
  logic [2:0]  cfg_frac;
  logic        cfg_mod5;
  logic [7:0]  cfg_dac;
  logic        div_pulse;
  logic [2:0]  acc_val;
  logic        comp_en;
  logic [10:0] comp_amp;

  int total = 0;
  int bad   = 0;
  int pend  = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  fracn_div_ctrl u_fracn_div_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ratio(cfg_ratio),
    .cfg_frac(cfg_frac), .cfg_mod5(cfg_mod5), .cfg_dac(cfg_dac),
    .div_pulse(div_pulse), .acc_val(acc_val), .comp_en(comp_en), .comp_amp(comp_amp)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_load(input int n, input int nf, input bit m5, input int dac);
    cfg_ratio = 16'(n);
    cfg_frac  = 3'(nf);
    cfg_mod5  = m5;
    cfg_dac   = 8'(dac);
    cfg_load  = 1'b1;
    @(negedge clk);
    pend++;
    cfg_load  = 1'b0;
  endtask

  // Length of the cycle in progress, then outputs one clock after its pulse.
  task automatic next_cycle(output int len, output int acc, output int en,
                            output int amp, output int pul);
    len = pend;
    forever begin
      @(negedge clk);
      len++;
      if (div_pulse) break;
    end
    @(negedge clk);
    acc  = acc_val;
    en   = comp_en;
    amp  = comp_amp;
    pul  = div_pulse;
    pend = 1;
  endtask

  task automatic sync_pulse();
    do @(negedge clk); while (!div_pulse);
    @(negedge clk);
    pend = 1;
  endtask

  task automatic run_cfg(input int n, input int nf, input bit m5, input int dac);
    int q, nfe, a, c, extra, exp_acc;
    int len, acc, en, amp, pul;
    q   = m5 ? 5 : 8;
    nfe = (m5 && nf > 4) ? 4 : nf;
    do_load(n, nf, m5, dac);
    next_cycle(len, acc, en, amp, pul);
    // R5: accumulator restarts at the reload boundary; R3 clamp shows here
    chk("R5", $sformatf("restart acc q=%0d nf=%0d", q, nf), acc, nfe);
    chk("R6", "window open after pulse", en, 1);
    chk("R7", "amp after reload", amp, nfe * dac);
    chk("R1", "pulse lasts one clock", pul, 0);
    a = 0;
    extra = 0;
    for (int k = 1; k <= q; k++) begin
      c = ((a + nfe) >= q) ? 1 : 0;
      a = (a + nfe) % q;
      exp_acc = (a + nfe) % q;
      next_cycle(len, acc, en, amp, pul);
      chk("R4", $sformatf("len q=%0d nf=%0d k=%0d", q, nf, k), len, n + c);
      chk("R2", $sformatf("acc q=%0d nf=%0d k=%0d", q, nf, k), acc, exp_acc);
      chk("R7", $sformatf("amp q=%0d nf=%0d k=%0d", q, nf, k), amp, exp_acc * dac);
      extra += len - n;
    end
    chk("R4", $sformatf("stretched count q=%0d nf=%0d", q, nf), extra, nfe);
    chk("R3", $sformatf("period returns to zero q=%0d nf=%0d", q, nf), a, 0);
  endtask

  initial begin
    int len, acc, en, amp, pul, w;
    rst_n     = 1'b0;
    cfg_load  = 1'b0;
    cfg_ratio = '0;
    cfg_frac  = '0;
    cfg_mod5  = 1'b0;
    cfg_dac   = '0;
    repeat (3) @(negedge clk);
    chk("R9", "acc in reset", acc_val, 0);
    chk("R9", "comp_en in reset", comp_en, 0);
    chk("R9", "comp_amp in reset", comp_amp, 0);
    chk("R1", "pulse in reset", div_pulse, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9", "acc after release", acc_val, 0);
    chk("R9", "comp_en after release", comp_en, 0);
    sync_pulse();
    next_cycle(len, acc, en, amp, pul);
    chk("R9", "reset ratio length", len, 512);
    chk("R9", "reset acc stays zero", acc, 0);

    // R5: mid-cycle load leaves the running cycle alone
    do_load(600, 0, 1'b0, 0);
    next_cycle(len, acc, en, amp, pul);
    chk("R5", "cycle during load keeps old ratio", len, 512);
    next_cycle(len, acc, en, amp, pul);
    chk("R5", "new ratio after boundary", len, 600);
    // R8: ratio floor
    do_load(100, 0, 1'b0, 0);
    next_cycle(len, acc, en, amp, pul);
    chk("R5", "old ratio before floor reload", len, 600);
    next_cycle(len, acc, en, amp, pul);
    chk("R8", "ratio below floor raised", len, 512);

    // Sweep every increment under both moduli
    for (int nf = 0; nf < 8; nf++) run_cfg(512, nf, 1'b0, 80);
    for (int nf = 0; nf < 8; nf++) run_cfg(512, nf, 1'b1, 128);
    run_cfg(1000, 3, 1'b1, 128);

    // R6/R7: window width and gating of the amplitude
    run_cfg(512, 2, 1'b1, 128);
    do @(negedge clk); while (!div_pulse);
    chk("R6", "window closed at pulse", comp_en, 0);
    chk("R7", "amp zero outside window", comp_amp, 0);
    w = 0;
    forever begin
      @(negedge clk);
      if (comp_en) w++;
      else break;
    end
    chk("R6", "window width", w, 128);
    chk("R7", "amp zero after window", comp_amp, 0);
    sync_pulse();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule